// File: doc/BRIEF.md
# UART Channel Command and Mode-Pointer Decoder

This block is the control-register front end of one UART channel. The CPU side presents one register access per cycle, made up of a valid strobe, a read/write flag, a register select and the 4-bit miscellaneous-command field. The block keeps a two-entry pointer that chooses which of the two mode registers the next mode access reaches. It turns each accepted write of the command field into a single-cycle pulse on one bit of a pulse vector. The receiver, the transmitter, the break timer and the counter/timer each take the bit they need from that vector.

The block also holds two levels that the commands set or clear: the active-low request-to-send output and the timeout-mode flag. Writes to the command field must be spaced by a minimum number of reference-clock edges, which reach the block as a one-cycle tick on the system clock. A command write that arrives too early is dropped and leaves a sticky violation flag set.

Top module: `uart_cmd_front`

## Requirements
- R1: While reset is held and after it is released, `mode_ptr_o` is 0 (first mode register), `rtsn_o` is 1, `tmo_mode_o` is 0, `spacing_viol_o` is 0 and `cmd_pulse_o` is all zero.
- R2: A mode-register access (valid, `acc_sel_i` = 0, read or write) made while `mode_ptr_o` is 0 sets `mode_ptr_o` to 1 from the next cycle on. A mode access made while it is 1 leaves it at 1.
- R3: An accepted command write with code 4'b0001 returns `mode_ptr_o` to 0 from the next cycle on.
- R4: An accepted command write (valid, write, `acc_sel_i` = 2) with code c in 1..10 raises `cmd_pulse_o[c-1]`, and code 4'b1100 raises `cmd_pulse_o[10]`. The pulse is high for exactly the one cycle after the write. Bit map: 0 pointer reset, 1 receiver reset, 2 transmitter reset, 3 error-status clear, 4 break-change interrupt clear, 5 break start, 6 break stop, 7 RTS assert, 8 RTS negate, 9 timeout mode on, 10 timeout mode off.
- R5: Codes 4'b0000, 4'b1011, 4'b1101, 4'b1110 and 4'b1111 raise no pulse and change neither the pointer, `rtsn_o` nor `tmo_mode_o`.
- R6: Code 4'b1000 drives `rtsn_o` to 0 and code 4'b1001 drives it to 1, both from the cycle after the write. The level holds between commands.
- R7: Code 4'b1010 sets `tmo_mode_o` and code 4'b1100 clears it, both from the cycle after the write.
- R8: A command write is accepted only when at least 3 reference ticks (`ref_tick_i` high cycles) have occurred since the last accepted command write. The first command write after reset is always accepted. A write that is not accepted has no effect on pulses, pointer or levels.
- R9: A command write that is not accepted sets `spacing_viol_o`, which then stays 1 until reset.
- R10: At most one bit of `cmd_pulse_o` is high in any cycle. Reads of the command select and writes to other selects (1 or 3) raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle marker of a reference-clock edge |
| acc_valid_i | input | 1 | A register access is presented this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 2 | Register select: 0 mode register, 2 command register |
| acc_cmd_i | input | 4 | Miscellaneous-command field of a command write |
| mode_ptr_o | output | 1 | Mode-register pointer: 0 first, 1 second |
| cmd_pulse_o | output | 11 | One-cycle command pulses, bit map in R4 |
| rtsn_o | output | 1 | Active-low request-to-send level |
| tmo_mode_o | output | 1 | Timeout-mode flag |
| spacing_viol_o | output | 1 | Sticky flag: a command write came too early |

## Verification
The decoder is driven with every one of the sixteen codes. Each of the eleven defined codes must light only its own pulse bit for one cycle, and the five idle codes must light nothing and leave the levels as they were, which separates a correct decode from one that is shifted or off by one. The pointer is exercised with a read, a repeated write and a pointer-reset command, which distinguishes advance-on-first-access from toggling. Command writes are spaced at exactly two and then exactly three ticks, which pins down the acceptance boundary and shows that a dropped write neither restarts the spacing nor clears the sticky flag.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

  localparam int CODE_W     = 4;
  localparam int NUM_PULSES = 11;

  typedef logic [CODE_W-1:0]     cmd_code_t;
  typedef logic [NUM_PULSES-1:0] pulse_vec_t;

  // Command codes; values are fixed by software.
  localparam cmd_code_t CMD_NONE      = 4'h0;
  localparam cmd_code_t CMD_PTR_RST   = 4'h1;
  localparam cmd_code_t CMD_RX_RST    = 4'h2;
  localparam cmd_code_t CMD_TX_RST    = 4'h3;
  localparam cmd_code_t CMD_ERR_CLR   = 4'h4;
  localparam cmd_code_t CMD_BRKI_CLR  = 4'h5;
  localparam cmd_code_t CMD_BRK_START = 4'h6;
  localparam cmd_code_t CMD_BRK_STOP  = 4'h7;
  localparam cmd_code_t CMD_RTS_ON    = 4'h8;
  localparam cmd_code_t CMD_RTS_OFF   = 4'h9;
  localparam cmd_code_t CMD_TMO_ON    = 4'hA;
  localparam cmd_code_t CMD_TMO_OFF   = 4'hC;

  // Pulse vector bit positions
  localparam int P_PTR_RST   = 0;
  localparam int P_RX_RST    = 1;
  localparam int P_TX_RST    = 2;
  localparam int P_ERR_CLR   = 3;
  localparam int P_BRKI_CLR  = 4;
  localparam int P_BRK_START = 5;
  localparam int P_BRK_STOP  = 6;
  localparam int P_RTS_ON    = 7;
  localparam int P_RTS_OFF   = 8;
  localparam int P_TMO_ON    = 9;
  localparam int P_TMO_OFF   = 10;

  function automatic pulse_vec_t decode_cmd(input cmd_code_t code);
    pulse_vec_t v;
    v = '0;
    case (code)
      CMD_PTR_RST:   v[P_PTR_RST]   = 1'b1;
      CMD_RX_RST:    v[P_RX_RST]    = 1'b1;
      CMD_TX_RST:    v[P_TX_RST]    = 1'b1;
      CMD_ERR_CLR:   v[P_ERR_CLR]   = 1'b1;
      CMD_BRKI_CLR:  v[P_BRKI_CLR]  = 1'b1;
      CMD_BRK_START: v[P_BRK_START] = 1'b1;
      CMD_BRK_STOP:  v[P_BRK_STOP]  = 1'b1;
      CMD_RTS_ON:    v[P_RTS_ON]    = 1'b1;
      CMD_RTS_OFF:   v[P_RTS_OFF]   = 1'b1;
      CMD_TMO_ON:    v[P_TMO_ON]    = 1'b1;
      CMD_TMO_OFF:   v[P_TMO_OFF]   = 1'b1;
      default:       v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/uart_cmd_spacer.sv
// Enforces the minimum reference-edge gap between command writes.
module uart_cmd_spacer #(
  parameter int MIN_EDGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wr_i,
  output logic accept_o,
  output logic viol_o
);

  localparam int CNT_W = (MIN_EDGES < 1) ? 1 : $clog2(MIN_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MIN_EDGES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             viol_q, viol_d;
  logic             ready;
  logic             cnt_en;

  assign ready    = (cnt_q >= CNT_FULL);
  assign accept_o = wr_i & ready;
  assign viol_o   = viol_q;

  always_comb begin
    cnt_en = accept_o | (tick_i & ~ready);
    cnt_d  = cnt_q;
    if (accept_o) begin
      cnt_d = '0;
    end else if (tick_i && !ready) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    viol_d = viol_q | (wr_i & ~ready);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_FULL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
    end else begin
      viol_q <= viol_d;
    end
  end

endmodule

// File: rtl/uart_cmd_decoder.sv
// Turns accepted command codes into registered pulses and held levels.
module uart_cmd_decoder
  import uart_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  cmd_code_t  code_i,
  output pulse_vec_t pulse_o,
  output logic       rtsn_o,
  output logic       tmo_o
);

  pulse_vec_t dec;
  pulse_vec_t pulse_q, pulse_d;
  logic       rtsn_q, rtsn_d;
  logic       tmo_q, tmo_d;
  logic       lvl_en;

  always_comb begin
    dec     = decode_cmd(code_i);
    pulse_d = accept_i ? dec : '0;
    lvl_en  = accept_i;
    rtsn_d  = rtsn_q;
    tmo_d   = tmo_q;
    if (dec[P_RTS_ON])  rtsn_d = 1'b0;
    if (dec[P_RTS_OFF]) rtsn_d = 1'b1;
    if (dec[P_TMO_ON])  tmo_d  = 1'b1;
    if (dec[P_TMO_OFF]) tmo_d  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= '0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rtsn_q <= 1'b1;
      tmo_q  <= 1'b0;
    end else if (lvl_en) begin
      rtsn_q <= rtsn_d;
      tmo_q  <= tmo_d;
    end
  end

  assign pulse_o = pulse_q;
  assign rtsn_o  = rtsn_q;
  assign tmo_o   = tmo_q;

endmodule

// File: rtl/uart_mr_pointer.sv
// Two-entry mode-register pointer: advances on first access, reset by command.
module uart_mr_pointer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_acc_i,
  input  logic ptr_rst_i,
  output logic ptr_o
);

  logic ptr_q, ptr_d, ptr_en;

  always_comb begin
    ptr_en = ptr_rst_i | (mode_acc_i & ~ptr_q);
    ptr_d  = ptr_q;
    if (ptr_rst_i) begin
      ptr_d = 1'b0;
    end else if (mode_acc_i) begin
      ptr_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= 1'b0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/uart_cmd_front.sv
module uart_cmd_front
  import uart_cmd_pkg::*;
#(
  parameter int          MIN_EDGES = 3,
  parameter int          SEL_W     = 2,
  parameter logic [1:0]  SEL_MODE  = 2'd0,
  parameter logic [1:0]  SEL_CMD   = 2'd2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ref_tick_i,
  input  logic                  acc_valid_i,
  input  logic                  acc_write_i,
  input  logic [SEL_W-1:0]      acc_sel_i,
  input  logic [CODE_W-1:0]     acc_cmd_i,
  output logic                  mode_ptr_o,
  output logic [NUM_PULSES-1:0] cmd_pulse_o,
  output logic                  rtsn_o,
  output logic                  tmo_mode_o,
  output logic                  spacing_viol_o
);

  logic cmd_wr;
  logic mode_acc;
  logic cmd_accept;
  logic ptr_rst;

  assign cmd_wr   = acc_valid_i & acc_write_i & (acc_sel_i == SEL_W'(SEL_CMD));
  assign mode_acc = acc_valid_i & (acc_sel_i == SEL_W'(SEL_MODE));
  assign ptr_rst  = cmd_accept & (acc_cmd_i == CMD_PTR_RST);

  uart_cmd_spacer #(
    .MIN_EDGES (MIN_EDGES)
  ) spacer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (ref_tick_i),
    .wr_i     (cmd_wr),
    .accept_o (cmd_accept),
    .viol_o   (spacing_viol_o)
  );

  uart_cmd_decoder decoder_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (cmd_accept),
    .code_i   (acc_cmd_i),
    .pulse_o  (cmd_pulse_o),
    .rtsn_o   (rtsn_o),
    .tmo_o    (tmo_mode_o)
  );

  uart_mr_pointer pointer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_acc_i (mode_acc),
    .ptr_rst_i  (ptr_rst),
    .ptr_o      (mode_ptr_o)
  );

endmodule

// File: rtl/uart_cmd_front_chk.sv
module uart_cmd_front_chk
  import uart_cmd_pkg::*;
#(
  parameter int         MIN_EDGES = 3,
  parameter int         SEL_W     = 2,
  parameter logic [1:0] SEL_MODE  = 2'd0
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ref_tick_i,
  input logic                  acc_valid_i,
  input logic [SEL_W-1:0]      acc_sel_i,
  input logic                  mode_ptr_o,
  input logic [NUM_PULSES-1:0] cmd_pulse_o,
  input logic                  rtsn_o,
  input logic                  tmo_mode_o,
  input logic                  spacing_viol_o
);

  localparam int SEEN_W = $clog2(MIN_EDGES + 2);
  localparam logic [SEEN_W-1:0] SEEN_SAT = SEEN_W'(MIN_EDGES);

  // Reference ticks seen since the last pulse (saturating).
  logic [SEEN_W-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= SEEN_SAT;
    end else if (cmd_pulse_o != '0) begin
      seen_q <= ref_tick_i ? SEEN_W'(1) : '0;
    end else if (ref_tick_i && seen_q < SEEN_SAT) begin
      seen_q <= seen_q + SEEN_W'(1);
    end
  end

  p_pulse_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_pulse_o));

  p_pulse_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pulse_o != '0) |=> (cmd_pulse_o == '0));

  p_ptr_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_sel_i == SEL_W'(SEL_MODE) && !mode_ptr_o) |=> mode_ptr_o);

  p_ptr_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pulse_o[P_PTR_RST] |-> !mode_ptr_o);

  p_rts_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pulse_o[P_RTS_ON] |-> !rtsn_o);

  p_rts_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pulse_o[P_RTS_OFF] |-> rtsn_o);

  p_tmo_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pulse_o[P_TMO_ON] |-> tmo_mode_o);

  p_tmo_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pulse_o[P_TMO_OFF] |-> !tmo_mode_o);

  p_spacing_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pulse_o != '0) |-> (seen_q >= SEEN_SAT));

  p_viol_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spacing_viol_o |=> spacing_viol_o);

endmodule

bind uart_cmd_front uart_cmd_front_chk #(
  .MIN_EDGES (MIN_EDGES),
  .SEL_W     (SEL_W),
  .SEL_MODE  (SEL_MODE)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ref_tick_i     (ref_tick_i),
  .acc_valid_i    (acc_valid_i),
  .acc_sel_i      (acc_sel_i),
  .mode_ptr_o     (mode_ptr_o),
  .cmd_pulse_o    (cmd_pulse_o),
  .rtsn_o         (rtsn_o),
  .tmo_mode_o     (tmo_mode_o),
  .spacing_viol_o (spacing_viol_o)
);

// File: tb/uart_cmd_front_tb.sv
module uart_cmd_front_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_MODE = 2'd0;
  localparam logic [1:0] S_CMD  = 2'd2;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        valid;
  logic        write;
  logic [1:0]  sel;
  logic [3:0]  code;
  logic        ptr;
  logic [10:0] pulse;
  logic        rtsn;
  logic        tmo;
  logic        viol;

  int vectors;
  int miscompares;
  bit finished;

  uart_cmd_front dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .ref_tick_i     (tick),
    .acc_valid_i    (valid),
    .acc_write_i    (write),
    .acc_sel_i      (sel),
    .acc_cmd_i      (code),
    .mode_ptr_o     (ptr),
    .cmd_pulse_o    (pulse),
    .rtsn_o         (rtsn),
    .tmo_mode_o     (tmo),
    .spacing_viol_o (viol)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic access(input logic [1:0] s, input logic w, input logic [3:0] c);
    valid = 1'b1;
    write = w;
    sel   = s;
    code  = c;
    @(negedge clk);
    valid = 1'b0;
    write = 1'b0;
  endtask

  task automatic t_reset_r1;
    check("R1 ptr",   32'(ptr),   32'd0);
    check("R1 rtsn",  32'(rtsn),  32'd1);
    check("R1 tmo",   32'(tmo),   32'd0);
    check("R1 viol",  32'(viol),  32'd0);
    check("R1 pulse", 32'(pulse), 32'd0);
  endtask

  task automatic t_pointer_r2_r3;
    access(S_MODE, 1'b0, 4'h0);
    check("R2 advance on read", 32'(ptr), 32'd1);
    access(S_MODE, 1'b1, 4'h0);
    check("R2 hold on second access", 32'(ptr), 32'd1);
    give_ticks(3);
    access(S_CMD, 1'b1, 4'h1);
    check("R3 pointer back to first", 32'(ptr), 32'd0);
    check("R3 pulse bit0", 32'(pulse), 32'h001);
    @(negedge clk);
    check("R4 pulse one cycle", 32'(pulse), 32'd0);
  endtask

  task automatic t_all_codes_r4;
    for (int c = 2; c <= 12; c++) begin
      if (c != 11) begin
        int idx;
        idx = (c == 12) ? 10 : c - 1;
        give_ticks(3);
        access(S_CMD, 1'b1, 4'(c));
        check($sformatf("R4 code %0d pulse", c), 32'(pulse), 32'(1) << idx);
        @(negedge clk);
        check($sformatf("R4 code %0d clears", c), 32'(pulse), 32'd0);
      end
    end
  endtask

  task automatic t_idle_codes_r5;
    logic [3:0] idle [5];
    idle = '{4'h0, 4'hB, 4'hD, 4'hE, 4'hF};
    // put levels in a known non-reset state first
    give_ticks(3);
    access(S_CMD, 1'b1, 4'h8);
    give_ticks(3);
    access(S_CMD, 1'b1, 4'hA);
    access(S_MODE, 1'b0, 4'h0);
    for (int k = 0; k < 5; k++) begin
      give_ticks(3);
      access(S_CMD, 1'b1, idle[k]);
      check($sformatf("R5 code %0h no pulse", idle[k]), 32'(pulse), 32'd0);
      check($sformatf("R5 code %0h rtsn", idle[k]), 32'(rtsn), 32'd0);
      check($sformatf("R5 code %0h tmo", idle[k]), 32'(tmo), 32'd1);
      check($sformatf("R5 code %0h ptr", idle[k]), 32'(ptr), 32'd1);
    end
  endtask

  task automatic t_levels_r6_r7;
    give_ticks(3);
    access(S_CMD, 1'b1, 4'h9);
    check("R6 rts negate", 32'(rtsn), 32'd1);
    give_ticks(3);
    access(S_CMD, 1'b1, 4'h8);
    check("R6 rts assert", 32'(rtsn), 32'd0);
    give_ticks(5);
    check("R6 level held", 32'(rtsn), 32'd0);
    give_ticks(3);
    access(S_CMD, 1'b1, 4'hC);
    check("R7 timeout off", 32'(tmo), 32'd0);
    give_ticks(3);
    access(S_CMD, 1'b1, 4'hA);
    check("R7 timeout on", 32'(tmo), 32'd1);
  endtask

  task automatic t_other_access_r10;
    give_ticks(3);
    access(S_CMD, 1'b0, 4'h9);
    check("R10 command read no pulse", 32'(pulse), 32'd0);
    access(2'd1, 1'b1, 4'h9);
    check("R10 sel1 write no pulse", 32'(pulse), 32'd0);
    access(2'd3, 1'b1, 4'h9);
    check("R10 sel3 write no pulse", 32'(pulse), 32'd0);
    check("R10 rtsn untouched", 32'(rtsn), 32'd0);
    check("R9 no violation yet", 32'(viol), 32'd0);
  endtask

  task automatic t_spacing_r8_r9;
    give_ticks(3);
    access(S_CMD, 1'b1, 4'h8);
    check("R8 first accepted", 32'(pulse), 32'h080);
    give_ticks(2);
    access(S_CMD, 1'b1, 4'h9);
    check("R8 early write dropped pulse", 32'(pulse), 32'd0);
    check("R8 early write dropped rtsn", 32'(rtsn), 32'd0);
    check("R9 violation set", 32'(viol), 32'd1);
    give_ticks(1);
    access(S_CMD, 1'b1, 4'h9);
    check("R8 accepted at three ticks", 32'(pulse), 32'h100);
    check("R8 rtsn after accept", 32'(rtsn), 32'd1);
    check("R9 violation sticky", 32'(viol), 32'd1);
  endtask

  initial begin
    vectors     = 0;
    miscompares = 0;
    finished    = 1'b0;
    rst_n = 1'b0;
    tick  = 1'b0;
    valid = 1'b0;
    write = 1'b0;
    sel   = 2'd0;
    code  = 4'h0;
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_pointer_r2_r3();
    t_all_codes_r4();
    t_idle_codes_r5();
    t_levels_r6_r7();
    t_other_access_r10();
    t_spacing_r8_r9();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule